// File: doc/BRIEF.md
# Overload Fault Timer with Latch or Auto-Recovery

This block decides when a switching power stage must stop because of a sustained overload or a shorted winding. A prescaler divides the clock into a slow sampling tick, nominally 10 ms. On each tick the block samples a maximum-current flag that comes from an external comparator. It uses that sample to move a small fault count up or down. The count integrates the overload instead of restarting on every gap, so short bursts of heavy load are forgiven while a persistent overload eventually trips. When the count reaches its completion value, eight ticks or about 80 ms by default, the drive enable falls.

A version strap chooses the outcome of a stop. In the latched variant, drive stays off and a supply-clamp request is held until an external un-latch event reports that the supply current has collapsed. In the auto-recovery variant, the block stays off until the supply has decayed to its undervoltage threshold and then restarts. Every restart clears the count and the prescaler. Each restart also raises a one-cycle pulse that launches the soft-start logic.

A separate winding-short flag stops drive at the next clock edge, whatever the count is. The outcome follows the same strap choice. All flags are plain level inputs. The block has no data stream, so there is no valid/ready interface.

Top module: `ovl_guard`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) enables drive, clears the latched status, the clamp request, the restart pulse, the fault count and the prescaler; it also releases an existing latch.
- R2: While running, each tick with the maximum-current flag high adds one to the fault count. Ticks fall on every TICK_CYCLES-th edge after the reset release or after a restart edge. Drive falls at the very tick edge on which the count reaches TRIP_COUNT, and not earlier.
- R3: Each tick with the flag low subtracts one from the count, and the count never goes below zero. Example: 5 high ticks, then 2 low ticks, then 5 high ticks trips on the last tick.
- R4: The maximum-current flag matters only at tick edges; its value on all other edges has no effect on the count or on drive.
- R5: With the strap at 1 (latched), a stop holds drive at 0 and both latched_o and vcc_clamp_o at 1 until unlatch_i is seen high at an edge; uvlo_evt_i is ignored in this state.
- R6: With the strap at 0 (auto-recovery), a stop holds drive at 0 with latched_o and vcc_clamp_o at 0 until uvlo_evt_i is seen high at an edge; unlatch_i is ignored in this state.
- R7: The edge that leaves a stop re-enables drive, clears the fault count and restarts the prescaler. It raises restart_o for exactly that one cycle.
- R8: A winding-short flag high at an edge while running drops drive at that edge and enters the stop chosen by the strap.
- R9: The strap is taken at the edge that stops the block; changing it while stopped does not change the kind of stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| over_limit_i | input | 1 | Maximum-current flag, sampled at each tick |
| wind_short_i | input | 1 | Winding-short flag, immediate stop |
| latch_mode_i | input | 1 | Version strap: 1 latched, 0 auto-recovery |
| uvlo_evt_i | input | 1 | Supply has decayed to its off threshold |
| unlatch_i | input | 1 | Supply current below hold level, releases latch |
| drive_en_o | output | 1 | Switching allowed |
| latched_o | output | 1 | Block is latched off |
| vcc_clamp_o | output | 1 | Request to clamp the supply while latched |
| restart_o | output | 1 | One-cycle pulse starting soft-start after a restart |

## Verification
The bench builds the block with TICK_CYCLES = 4 and TRIP_COUNT = 8, so one tick lasts four cycles and a full trip takes only 32 cycles. This makes it affordable to sweep all 256 eight-tick patterns of the current flag, alternating the strap. Each pattern is followed by a run of high ticks up to the trip, and the bench predicts every trip edge from an arithmetic up/down count with a floor at zero. The flag is driven to the opposite value on the cycles between ticks, which exercises tick-only sampling. Winding shorts at an arbitrary phase, strap changes while stopped, the ignored release event and a reset during a latch are tested separately.

// File: rtl/ovl_guard_pkg.sv
package ovl_guard_pkg;

  // Run/stop state of the fault manager
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LATCH = 2'd1,
    ST_WAIT  = 2'd2
  } ovl_state_e;

endpackage

// File: rtl/ovl_tick_gen.sv
module ovl_tick_gen #(
  parameter int TICK_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);

  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;

  // Prescaler is held at zero whenever the stage is stopped, so a restart
  // begins a fresh tick period.
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pre_q <= '0;
    end else if (pre_q == LAST) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign tick_o = run_i && (pre_q == LAST);

endmodule

// File: rtl/ovl_fault_integ.sv
module ovl_fault_integ #(
  parameter int TRIP_COUNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  input  logic over_i,
  output logic expire_o
);

  localparam int CNT_W = $clog2(TRIP_COUNT + 1);
  localparam logic [CNT_W-1:0] TOP    = CNT_W'(TRIP_COUNT);
  localparam logic [CNT_W-1:0] PRETOP = CNT_W'(TRIP_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;

  // Up/down integrator with a floor at zero and a ceiling at completion
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (over_i) begin
        if (cnt_q != TOP) cnt_q <= cnt_q + CNT_W'(1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // Completion is flagged on the tick that would carry the count to the top
  assign expire_o = run_i && tick_i && over_i && (cnt_q == PRETOP);

endmodule

// File: rtl/ovl_fault_fsm.sv
module ovl_fault_fsm
  import ovl_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic short_i,
  input  logic latch_mode_i,
  input  logic uvlo_i,
  input  logic unlatch_i,
  output logic run_o,
  output logic latched_o,
  output logic restart_o
);

  ovl_state_e state_q, state_d;
  logic       restart_q, restart_d;

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (expire_i || short_i) begin
          state_d = latch_mode_i ? ST_LATCH : ST_WAIT;
        end
      end
      ST_LATCH: begin
        if (unlatch_i) begin
          state_d   = ST_RUN;
          restart_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (uvlo_i) begin
          state_d   = ST_RUN;
          restart_d = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign latched_o = (state_q == ST_LATCH);
  assign restart_o = restart_q;

endmodule

// File: rtl/ovl_guard.sv
module ovl_guard #(
  parameter int TICK_CYCLES = 500000,
  parameter int TRIP_COUNT  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic over_limit_i,
  input  logic wind_short_i,
  input  logic latch_mode_i,
  input  logic uvlo_evt_i,
  input  logic unlatch_i,
  output logic drive_en_o,
  output logic latched_o,
  output logic vcc_clamp_o,
  output logic restart_o
);

  logic run;
  logic tick;
  logic expire;
  logic latched;

  ovl_tick_gen #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .tick_o (tick)
  );

  ovl_fault_integ #(
    .TRIP_COUNT(TRIP_COUNT)
  ) u_integ (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .tick_i   (tick),
    .over_i   (over_limit_i),
    .expire_o (expire)
  );

  ovl_fault_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .expire_i     (expire),
    .short_i      (wind_short_i),
    .latch_mode_i (latch_mode_i),
    .uvlo_i       (uvlo_evt_i),
    .unlatch_i    (unlatch_i),
    .run_o        (run),
    .latched_o    (latched),
    .restart_o    (restart_o)
  );

  assign drive_en_o  = run;
  assign latched_o   = latched;
  assign vcc_clamp_o = latched;

endmodule

// File: rtl/ovl_guard_chk.sv
module ovl_guard_chk (
  input logic clk,
  input logic rst,
  input logic wind_short_i,
  input logic uvlo_evt_i,
  input logic unlatch_i,
  input logic drive_en_o,
  input logic latched_o,
  input logic vcc_clamp_o,
  input logic restart_o
);

  p_latch_blocks_drive_r5: assert property (@(posedge clk) disable iff (rst)
    latched_o |-> (!drive_en_o && vcc_clamp_o));

  p_latch_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (latched_o && !unlatch_i) |=> latched_o);

  p_unlatch_resumes_r5: assert property (@(posedge clk) disable iff (rst)
    (latched_o && unlatch_i) |=> (drive_en_o && restart_o));

  p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!drive_en_o && !latched_o && !uvlo_evt_i) |=> !drive_en_o);

  p_restart_single_r7: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  p_restart_with_drive_r7: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> drive_en_o);

  p_short_stops_r8: assert property (@(posedge clk) disable iff (rst)
    (drive_en_o && wind_short_i) |=> !drive_en_o);

endmodule

bind ovl_guard ovl_guard_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .wind_short_i (wind_short_i),
  .uvlo_evt_i   (uvlo_evt_i),
  .unlatch_i    (unlatch_i),
  .drive_en_o   (drive_en_o),
  .latched_o    (latched_o),
  .vcc_clamp_o  (vcc_clamp_o),
  .restart_o    (restart_o)
);

// File: tb/ovl_guard_bench.sv
module ovl_guard_bench;

  localparam int TICK = 4;
  localparam int TRIP = 8;

  logic clk = 1'b0;
  logic rst, over_limit, wind_short, latch_mode, uvlo_evt, unlatch;
  logic drive_en, latched, vcc_clamp, restart;

  int checks = 0;
  int errors = 0;
  int mcnt   = 0;

  always #10 clk = ~clk;

  ovl_guard #(
    .TICK_CYCLES(TICK),
    .TRIP_COUNT (TRIP)
  ) u_ovl_guard (
    .clk          (clk),
    .rst          (rst),
    .over_limit_i (over_limit),
    .wind_short_i (wind_short),
    .latch_mode_i (latch_mode),
    .uvlo_evt_i   (uvlo_evt),
    .unlatch_i    (unlatch),
    .drive_en_o   (drive_en),
    .latched_o    (latched),
    .vcc_clamp_o  (vcc_clamp),
    .restart_o    (restart)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One tick window while running; the flag carries the opposite value
  // on every edge except the tick edge (R4).
  task automatic tick(input bit ov, output bit tr);
    over_limit = !ov;
    cyc(1);
    chk("R7 restart pulse lasts one cycle", restart, 1'b0);
    cyc(TICK - 2);
    chk("R4 flag between ticks has no effect", drive_en, 1'b1);
    over_limit = ov;
    cyc(1);
    if (ov) mcnt++;
    else if (mcnt > 0) mcnt--;
    tr = (mcnt == TRIP);
    if (ov) chk("R2 count up and trip edge", drive_en, !tr);
    else    chk("R3 count down with floor", drive_en, 1'b1);
    over_limit = 1'b0;
  endtask

  task automatic recover(input bit strap);
    chk("R5 drive off when stopped", drive_en, 1'b0);
    if (strap) begin
      chk("R5 latched status", latched, 1'b1);
      chk("R5 clamp request", vcc_clamp, 1'b1);
    end else begin
      chk("R6 no latch in recovery", latched, 1'b0);
      chk("R6 no clamp in recovery", vcc_clamp, 1'b0);
    end
    latch_mode = !strap;
    if (strap) begin
      uvlo_evt = 1'b1; cyc(1); uvlo_evt = 1'b0;
      chk("R5 undervoltage ignored while latched", drive_en, 1'b0);
      chk("R9 strap change while stopped ignored", latched, 1'b1);
    end else begin
      unlatch = 1'b1; cyc(1); unlatch = 1'b0;
      chk("R6 unlatch ignored in recovery", drive_en, 1'b0);
      chk("R9 strap change while stopped ignored", latched, 1'b0);
    end
    latch_mode = strap;
    if (strap) unlatch = 1'b1; else uvlo_evt = 1'b1;
    cyc(1);
    unlatch = 1'b0; uvlo_evt = 1'b0;
    chk("R7 drive back on restart", drive_en, 1'b1);
    chk("R7 restart pulse", restart, 1'b1);
    chk("R7 latch cleared on restart", latched, 1'b0);
    mcnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit tr;
    bit strap;
    rst = 1'b1; over_limit = 1'b0; wind_short = 1'b0;
    latch_mode = 1'b1; uvlo_evt = 1'b0; unlatch = 1'b0;
    cyc(3);
    chk("R1 reset drive enabled", drive_en, 1'b1);
    chk("R1 reset not latched", latched, 1'b0);
    chk("R1 reset no clamp", vcc_clamp, 1'b0);
    chk("R1 reset no restart", restart, 1'b0);
    rst = 1'b0;
    mcnt = 0;

    // Sweep of every eight-tick flag pattern, then high ticks up to the trip
    for (int p = 0; p < 256; p++) begin
      strap = p[0] ^ p[3];
      latch_mode = strap;
      for (int b = 0; b < 8; b++) begin
        tick(p[b], tr);
        if (tr) recover(strap);
      end
      tr = 1'b0;
      for (int k = 0; k < TRIP && !tr; k++) tick(1'b1, tr);
      chk("R2 trip reached within completion count", tr, 1'b1);
      if (tr) recover(strap);
    end

    // Winding short at an arbitrary phase, both straps
    for (int s = 0; s < 2; s++) begin
      latch_mode = s[0];
      tick(1'b1, tr);
      tick(1'b1, tr);
      cyc(1);
      wind_short = 1'b1;
      cyc(1);
      wind_short = 1'b0;
      chk("R8 winding short stops drive", drive_en, 1'b0);
      chk("R8 winding short follows strap", latched, s[0]);
      recover(s[0]);
    end

    // Reset releases an existing latch
    latch_mode = 1'b1;
    tr = 1'b0;
    for (int k = 0; k < TRIP; k++) tick(1'b1, tr);
    chk("R5 latched after trip", latched, 1'b1);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    mcnt = 0;
    chk("R1 reset releases latch", latched, 1'b0);
    chk("R1 reset re-enables drive", drive_en, 1'b1);
    chk("R1 reset drops clamp", vcc_clamp, 1'b0);
    tr = 1'b0;
    for (int k = 0; k < TRIP; k++) tick(1'b1, tr);
    chk("R1 count cleared by reset", tr, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule